// File: doc/BRIEF.md
# Bus Acknowledge Delay Generator

This block produces the active-low data-transfer acknowledge for a processor whose 16-bit bus is asynchronous: a bus cycle opens when the active-low address strobe falls, and the processor waits until the acknowledge goes low. A small binary counter is kept at zero while the strobe is high. It advances on each processor clock edge while the strobe is low. The acknowledge follows one chosen bit of that counter, inverted, so the wait before the acknowledge is a power of two in clock edges.

A two-bit static input picks the counter bit, and so the wait state count suited to the slowest memory on the bus. The counter stops once the chosen bit is set, so the acknowledge holds low for as long as the processor keeps the strobe low. It rises on the first edge after the strobe is released, which leaves the next bus cycle a clean start.

Top module: `ackdly_gen`

## Requirements
- R1: While synchronous reset `rst` is high at a rising edge, `ack_n` is 1 after that edge, whatever the strobe and select inputs do.
- R2: While `as_n` is 1 at each edge, the counter stays at zero and `ack_n` stays 1 for any number of edges.
- R3: With `dly_sel` = 0 (counter bit 0), `ack_n` goes to 0 after the 1st rising edge at which `as_n` is 0, and not earlier.
- R4: With `dly_sel` = 1 (counter bit 1), `ack_n` goes to 0 after the 2nd consecutive rising edge with `as_n` at 0, and is 1 after the 1st.
- R5: With `dly_sel` = 2 (counter bit 2), `ack_n` goes to 0 after the 4th consecutive rising edge with `as_n` at 0, and is 1 after edges 1 to 3.
- R6: `dly_sel` = 3 behaves exactly as `dly_sel` = 2, with a wait of 4 edges.
- R7: Once `ack_n` is 0, it stays 0 for every further edge at which `as_n` is still 0, however long the strobe is held. The counter saturates and does not wrap.
- R8: After the first rising edge at which `as_n` is 1, `ack_n` is 1.
- R9: A new strobe assertion after at least one edge with `as_n` at 1 counts again from zero, so it sees the full wait of R3 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| as_n | input | 1 | Address strobe from the processor, active low |
| dly_sel | input | 2 | Static choice of the counter bit: 0, 1, 2 pick bits 0, 1, 2; 3 picks bit 2 |
| ack_n | output | 1 | Registered data-transfer acknowledge, active low |

## Verification
The counter is internal, so any fault in it shows only in the timing of `ack_n`. An early or late tap shows as an acknowledge that falls one or more edges off the 1, 2 or 4 edge mark for that bus cycle. A counter that wraps raises `ack_n` again while the strobe is still low, within four edges of the fall. A counter that is not cleared shortens the wait of the next cycle, which the back-to-back cycles show at once. The sweep tries every select value against every strobe length up to well past saturation, so each of these faults is seen within the first cycle that exposes it.

// File: rtl/ackdly_pkg.sv
package ackdly_pkg;

    localparam int CNT_W = 3;
    localparam int SEL_W = 2;
    localparam int IDX_W = (CNT_W > 1) ? $clog2(CNT_W) : 1;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        cnt_t cnt;
    } cnt_state_t;

    typedef struct packed {
        logic ack_n;
    } ack_state_t;

endpackage

// File: rtl/ackdly_tap_sel.sv
module ackdly_tap_sel
    import ackdly_pkg::*;
#(
    parameter int NCNT = CNT_W,
    parameter int NSEL = SEL_W,
    localparam int NIDX = (NCNT > 1) ? $clog2(NCNT) : 1
) (
    input  logic [NSEL-1:0] sel,
    input  logic [NCNT-1:0] vec,
    output logic [NIDX-1:0] idx,
    output logic            bit_o
);

    localparam int LAST = NCNT - 1;

    // Select codes past the last counter bit fall back to the last bit.
    always_comb begin
        if (int'(sel) > LAST) begin
            idx = NIDX'(LAST);
        end else begin
            idx = NIDX'(sel);
        end
    end

    logic [NCNT-1:0] onehot;

    for (genvar g = 0; g < NCNT; g++) begin : g_tap
        assign onehot[g] = (int'(idx) == g) && vec[g];
    end

    assign bit_o = |onehot;

endmodule

// File: rtl/ackdly_counter.sv
module ackdly_counter
    import ackdly_pkg::*;
#(
    parameter int NCNT = CNT_W,
    localparam int NIDX = (NCNT > 1) ? $clog2(NCNT) : 1
) (
    input  logic            clk,
    input  logic            clr,
    input  logic [NIDX-1:0] idx,
    output logic [NCNT-1:0] cnt_nxt,
    output logic [NCNT-1:0] cnt_cur
);

    logic [NCNT-1:0] cnt_d, cnt_q;
    logic            at_tap;

    assign at_tap = cnt_q[idx];

    // Clear wins; the count stops once the chosen bit is set.
    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (!at_tap) begin
            cnt_d = cnt_q + NCNT'(1);
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign cnt_nxt = cnt_d;
    assign cnt_cur = cnt_q;

    logic past_ok_q;
    always_ff @(posedge clk) begin
        past_ok_q <= 1'b1;
    end

    // R2: a cleared counter reads zero on the next edge
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!past_ok_q)
        clr |=> (cnt_q == '0));

    // R7: a running count never falls back to zero without a clear
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!past_ok_q)
        (!clr && cnt_q != '0) |=> (cnt_q != '0));

endmodule

// File: rtl/ackdly_gen.sv
module ackdly_gen
    import ackdly_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             as_n,
    input  logic [SEL_W-1:0] dly_sel,
    output logic             ack_n
);

    idx_t       tap_idx;
    cnt_t       cnt_nxt;
    cnt_t       cnt_cur;
    logic       tap_hit;
    logic       clr;
    ack_state_t st_d, st_q;

    assign clr = rst | as_n;

    ackdly_tap_sel #(.NCNT(CNT_W), .NSEL(SEL_W)) u_tap (
        .sel   (dly_sel),
        .vec   (cnt_nxt),
        .idx   (tap_idx),
        .bit_o (tap_hit)
    );

    ackdly_counter #(.NCNT(CNT_W)) u_cnt (
        .clk     (clk),
        .clr     (clr),
        .idx     (tap_idx),
        .cnt_nxt (cnt_nxt),
        .cnt_cur (cnt_cur)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.ack_n = 1'b1;
        end else begin
            st_d.ack_n = ~tap_hit;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ack_n = st_q.ack_n;

    logic past_ok_q;
    always_ff @(posedge clk) begin
        past_ok_q <= 1'b1;
    end

    // R1: reset forces the acknowledge high
    a_r1_reset_high: assert property (@(posedge clk) disable iff (!past_ok_q)
        rst |=> ack_n);

    // R8: strobe released means acknowledge high one edge later
    a_r8_release: assert property (@(posedge clk) disable iff (!past_ok_q || rst)
        as_n |=> ack_n);

    // R7: acknowledge holds low while the strobe stays low
    a_r7_hold_low: assert property (@(posedge clk) disable iff (!past_ok_q || rst)
        (!ack_n && !as_n) |=> !ack_n);

    // R3: acknowledge low implies a nonzero count behind it
    a_r3_low_needs_count: assert property (@(posedge clk) disable iff (!past_ok_q || rst)
        !ack_n |-> (cnt_cur != '0));

endmodule

// File: tb/ackdly_gen_bench.sv
module ackdly_gen_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       as_n;
    logic [1:0] dly_sel;
    logic       ack_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ackdly_gen u_ackdly_gen (
        .clk     (clk),
        .rst     (rst),
        .as_n    (as_n),
        .dly_sel (dly_sel),
        .ack_n   (ack_n)
    );

    task automatic check(input logic exp, input string req);
        checks++;
        if (ack_n !== exp) begin
            errors++;
            $display("FAIL %s: ack_n=%b expected %b (sel=%0d)", req, ack_n, exp, dly_sel);
        end
    endtask

    function automatic string sel_req(input int s);
        case (s)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    // One bus cycle: strobe low for n edges, then released for idle edges.
    task automatic bus_cycle(input int s, input int n, input int idle);
        int wait_edges;
        wait_edges = 1 << ((s > 2) ? 2 : s);
        @(negedge clk);
        dly_sel = 2'(s);
        as_n = 1'b0;
        for (int i = 1; i <= n; i++) begin
            @(posedge clk); #1;
            if (i > wait_edges) check(1'b0, "R7");
            else check((i >= wait_edges) ? 1'b0 : 1'b1, sel_req(s));
        end
        @(negedge clk);
        as_n = 1'b1;
        for (int i = 0; i < idle; i++) begin
            @(posedge clk); #1;
            check(1'b1, (i == 0) ? "R8" : "R2");
        end
    endtask

    initial begin
        rst = 1'b1;
        as_n = 1'b0;
        dly_sel = 2'd0;
        repeat (3) begin
            @(posedge clk); #1;
            check(1'b1, "R1");
        end
        @(negedge clk);
        rst = 1'b0;
        as_n = 1'b1;
        repeat (6) begin
            @(posedge clk); #1;
            check(1'b1, "R2");
        end

        for (int s = 0; s < 4; s++) begin
            for (int n = 1; n <= 12; n++) begin
                bus_cycle(s, n, 2);
            end
            // R9: back-to-back cycles with a single idle edge
            for (int k = 0; k < 3; k++) begin
                bus_cycle(s, 6, 1);
            end
        end

        // R1: reset in the middle of a held cycle
        @(negedge clk);
        dly_sel = 2'd0;
        as_n = 1'b0;
        @(posedge clk); #1;
        check(1'b0, "R3");
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        check(1'b1, "R1");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        check(1'b0, "R9");
        @(negedge clk);
        as_n = 1'b1;
        @(posedge clk); #1;
        check(1'b1, "R8");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: run did not finish");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule